// File: doc/BRIEF.md
# Interrupt-Injecting Instruction Sequencer

This block sits between instruction fetch and decode in a processor with 12-bit words and a 15-bit address. An address is a 3-bit field selector followed by a 12-bit offset within a 4096-word field. Each fetched word comes in with its program counter. The block returns the following outputs one cycle later:

- the word that decode must act on;
- the return, or next, program counter;
- the program counter that decode should use;
- the 3-bit major opcode.

Normally the word passes through unchanged. The next address is the current address plus one, and the carry never leaves the current field.

A request to interrupt is held until the next instruction is accepted. That instruction is then replaced by a fixed subroutine-call word, 04000 octal. The return address is the un-incremented program counter, so the replaced instruction runs again after the handler. The decode address is forced to 0, which sends the call to location 0.

An interrupt may only be taken while both the data field and the instruction field are 0. If either is nonzero, the block still injects the call, and it flags a fault on that output beat. Both sides of the block use a valid/ready handshake, so a downstream stall holds the pipeline.

Top module: `instr_seq`

## Requirements
- R1: On a normal beat, out_next_pc keeps bits 14..12 of in_pc and equals the low 12 bits plus one modulo 4096, so offset 07777 wraps to 0 in the same field.
- R2: On a normal beat, out_word equals in_word and out_dec_pc equals in_pc.
- R3: On an interrupt beat, out_word is 04000 octal whatever in_word holds.
- R4: On an interrupt beat, out_next_pc equals in_pc, with no increment.
- R5: On an interrupt beat, out_dec_pc is 0.
- R6: out_opcode always equals bits 11..9 of out_word, so it is 3'b100 on an interrupt beat.
- R7: out_fault is 1 on an interrupt beat whose df or ifld was nonzero, and 0 on every other beat.
- R8: An accepted input appears at the outputs on the next cycle. The handshake follows three rules:
  - in_ready = !out_valid || out_ready;
  - while out_valid is high and out_ready is low, all outputs hold;
  - out_valid drops after a beat is taken downstream if no new input is accepted.
- R9: A high irq on any cycle makes a request pending. The pending request is consumed by exactly one interrupt beat, at the first accepted input (which may be in the same cycle). Later beats are normal until irq is raised again.
- R10: A synchronous reset clears out_valid, out_fault and any pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Fetched word and PC are present |
| in_ready | output | 1 | Block can accept this cycle |
| in_pc | input | 15 | Address of the fetched word (field, offset) |
| in_word | input | 12 | Fetched instruction word |
| irq | input | 1 | Interrupt request |
| df | input | 3 | Current data field |
| ifld | input | 3 | Current instruction field |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream accepts the beat |
| out_word | output | 12 | Effective instruction word |
| out_next_pc | output | 15 | Next sequential or return address |
| out_dec_pc | output | 15 | Address decode uses for this word |
| out_opcode | output | 3 | Major opcode of out_word |
| out_fault | output | 1 | Interrupt taken with a nonzero field |

## Verification
The bench uses the default widths: a 3-bit field and a 12-bit offset. With these widths, program counters of the form f7777 show the offset wrap without a carry into the field, in every one of the eight fields. Random values of df and ifld between 0 and 7 reach both the clean and the faulting interrupt beats. Random out_ready stalls, mixed with requests raised while no input is valid, exercise the latch-until-accept path and the hold path.

// File: rtl/instr_seq_pkg.sv
package instr_seq_pkg;
  localparam int unsigned FIELD_W_DEF  = 3;
  localparam int unsigned OFFSET_W_DEF = 12;
  localparam int unsigned OPC_W_DEF    = 3;
  typedef enum logic [0:0] {BEAT_PLAIN = 1'b0, BEAT_INJECT = 1'b1} beat_kind_e;
endpackage

// File: rtl/seq_pc_step.sv
module seq_pc_step #(
  parameter int unsigned FIELD_W  = 3,
  parameter int unsigned OFFSET_W = 12,
  localparam int unsigned PC_W    = FIELD_W + OFFSET_W
) (
  input  logic [PC_W-1:0] pc,
  output logic [PC_W-1:0] pc_inc
);
  logic [OFFSET_W-1:0] ofs_inc;
  assign ofs_inc = pc[OFFSET_W-1:0] + OFFSET_W'(1);

  generate
    if (FIELD_W > 0) begin : g_field
      assign pc_inc = {pc[PC_W-1:OFFSET_W], ofs_inc};
    end else begin : g_flat
      assign pc_inc = ofs_inc;
    end
  endgenerate
endmodule

// File: rtl/seq_irq_hold.sv
module seq_irq_hold (
  input  logic clk,
  input  logic rst,
  input  logic irq,
  input  logic accept,
  output logic take
);
  logic pend;
  assign take = accept & (pend | irq);

  always_ff @(posedge clk) begin
    if (rst)         pend <= 1'b0;
    else if (accept) pend <= 1'b0;
    else             pend <= pend | irq;
  end
endmodule

// File: rtl/seq_out_reg.sv
module seq_out_reg #(
  parameter int unsigned WORD_W = 12,
  parameter int unsigned PC_W   = 15,
  parameter int unsigned OPC_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] d_word,
  input  logic [PC_W-1:0]   d_next,
  input  logic [PC_W-1:0]   d_dec,
  input  logic [OPC_W-1:0]  d_opc,
  input  logic              d_fault,
  output logic [WORD_W-1:0] q_word,
  output logic [PC_W-1:0]   q_next,
  output logic [PC_W-1:0]   q_dec,
  output logic [OPC_W-1:0]  q_opc,
  output logic              q_fault
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_word  <= '0;
      q_next  <= '0;
      q_dec   <= '0;
      q_opc   <= '0;
      q_fault <= 1'b0;
    end else if (load) begin
      q_word  <= d_word;
      q_next  <= d_next;
      q_dec   <= d_dec;
      q_opc   <= d_opc;
      q_fault <= d_fault;
    end
  end
endmodule

// File: rtl/instr_seq.sv
module instr_seq
  import instr_seq_pkg::*;
#(
  parameter int unsigned FIELD_W  = FIELD_W_DEF,
  parameter int unsigned OFFSET_W = OFFSET_W_DEF,
  parameter int unsigned OPC_W    = OPC_W_DEF,
  parameter logic [OFFSET_W-1:0] CALL_WORD = 12'o4000,
  localparam int unsigned PC_W    = FIELD_W + OFFSET_W,
  localparam int unsigned FSEL_W  = (FIELD_W > 0) ? FIELD_W : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [PC_W-1:0]     in_pc,
  input  logic [OFFSET_W-1:0] in_word,
  input  logic                irq,
  input  logic [FSEL_W-1:0]   df,
  input  logic [FSEL_W-1:0]   ifld,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [OFFSET_W-1:0] out_word,
  output logic [PC_W-1:0]     out_next_pc,
  output logic [PC_W-1:0]     out_dec_pc,
  output logic [OPC_W-1:0]    out_opcode,
  output logic                out_fault
);
  logic            accept;
  logic            irq_take;
  beat_kind_e      kind;
  logic [PC_W-1:0] pc_inc;
  logic [OFFSET_W-1:0] eff_word;
  logic [PC_W-1:0]     eff_next;
  logic [PC_W-1:0]     eff_dec;
  logic                eff_fault;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  seq_irq_hold u_irq (
    .clk(clk), .rst(rst), .irq(irq), .accept(accept), .take(irq_take)
  );

  seq_pc_step #(.FIELD_W(FIELD_W), .OFFSET_W(OFFSET_W)) u_step (
    .pc(in_pc), .pc_inc(pc_inc)
  );

  assign kind = irq_take ? BEAT_INJECT : BEAT_PLAIN;

  always_comb begin
    unique case (kind)
      BEAT_INJECT: begin
        eff_word  = CALL_WORD;
        eff_next  = in_pc;
        eff_dec   = '0;
        eff_fault = (df != '0) || (ifld != '0);
      end
      default: begin
        eff_word  = in_word;
        eff_next  = pc_inc;
        eff_dec   = in_pc;
        eff_fault = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  seq_out_reg #(.WORD_W(OFFSET_W), .PC_W(PC_W), .OPC_W(OPC_W)) u_out (
    .clk(clk), .rst(rst), .load(accept),
    .d_word(eff_word), .d_next(eff_next), .d_dec(eff_dec),
    .d_opc(eff_word[OFFSET_W-1 -: OPC_W]), .d_fault(eff_fault),
    .q_word(out_word), .q_next(out_next_pc), .q_dec(out_dec_pc),
    .q_opc(out_opcode), .q_fault(out_fault)
  );
endmodule

// File: rtl/instr_seq_chk.sv
module instr_seq_chk #(
  parameter int unsigned FIELD_W  = 3,
  parameter int unsigned OFFSET_W = 12,
  parameter int unsigned OPC_W    = 3,
  parameter logic [OFFSET_W-1:0] CALL_WORD = 12'o4000,
  localparam int unsigned PC_W    = FIELD_W + OFFSET_W
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                in_ready,
  input logic [PC_W-1:0]     in_pc,
  input logic [OFFSET_W-1:0] in_word,
  input logic                irq_take,
  input logic                out_valid,
  input logic                out_ready,
  input logic [OFFSET_W-1:0] out_word,
  input logic [PC_W-1:0]     out_next_pc,
  input logic [PC_W-1:0]     out_dec_pc,
  input logic [OPC_W-1:0]    out_opcode,
  input logic                out_fault
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_next_pc)
      && $stable(out_dec_pc) && $stable(out_fault));

  assert_ready_R8: assert property (@(posedge clk) disable iff (rst)
    out_ready |-> in_ready);

  assert_opcode_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_opcode == out_word[OFFSET_W-1 -: OPC_W]);

  assert_fault_shape_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_fault |-> out_word == CALL_WORD && out_dec_pc == '0);

  assert_plain_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && !irq_take |=> out_valid && out_dec_pc == $past(in_pc)
      && out_word == $past(in_word) && !out_fault);

  assert_ret_pc_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && irq_take |=> out_next_pc == $past(in_pc)
      && out_word == CALL_WORD && out_dec_pc == '0);
endmodule

bind instr_seq instr_seq_chk #(
  .FIELD_W(FIELD_W), .OFFSET_W(OFFSET_W), .OPC_W(OPC_W), .CALL_WORD(CALL_WORD)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_pc(in_pc),
  .in_word(in_word), .irq_take(irq_take), .out_valid(out_valid), .out_ready(out_ready),
  .out_word(out_word), .out_next_pc(out_next_pc), .out_dec_pc(out_dec_pc),
  .out_opcode(out_opcode), .out_fault(out_fault)
);

// File: tb/sim_instr_seq.sv
module sim_instr_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [14:0] in_pc = '0;
  logic [11:0] in_word = '0;
  logic        irq = 1'b0;
  logic [2:0]  df = '0;
  logic [2:0]  ifld = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [11:0] out_word;
  logic [14:0] out_next_pc;
  logic [14:0] out_dec_pc;
  logic [2:0]  out_opcode;
  logic        out_fault;

  int total = 0;
  int bad   = 0;

  int m_valid = 0, m_word = 0, m_next = 0, m_dec = 0, m_fault = 0, m_pend = 0;

  always #2 clk = ~clk;

  instr_seq u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_pc(in_pc),
    .in_word(in_word), .irq(irq), .df(df), .ifld(ifld), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word), .out_next_pc(out_next_pc),
    .out_dec_pc(out_dec_pc), .out_opcode(out_opcode), .out_fault(out_fault)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0o exp=%0o", tag, act, exp);
    end
  endtask

  task automatic compare_out();
    chk("R8 out_valid", int'(out_valid), m_valid);
    if (m_valid != 0) begin
      chk("R2/R3 out_word", int'(out_word), m_word);
      chk("R1/R4 out_next_pc", int'(out_next_pc), m_next);
      chk("R2/R5 out_dec_pc", int'(out_dec_pc), m_dec);
      chk("R6 out_opcode", int'(out_opcode), m_word >> 9);
      chk("R7 out_fault", int'(out_fault), m_fault);
    end
  endtask

  task automatic step(input int v, input int pc, input int w, input int rq,
                      input int d, input int f, input int ordy);
    int rdy, acc, tk;
    @(negedge clk);
    compare_out();
    in_valid  = v[0];
    in_pc     = 15'(pc);
    in_word   = 12'(w);
    irq       = rq[0];
    df        = 3'(d);
    ifld      = 3'(f);
    out_ready = ordy[0];
    #1;
    rdy = (m_valid == 0 || ordy != 0) ? 1 : 0;
    chk("R8 in_ready", int'(in_ready), rdy);
    acc = (v != 0 && rdy != 0) ? 1 : 0;
    tk  = (acc != 0 && (m_pend != 0 || rq != 0)) ? 1 : 0;
    if (acc != 0) begin
      if (tk != 0) begin
        m_word = 'o4000; m_next = pc; m_dec = 0;
        m_fault = (d != 0 || f != 0) ? 1 : 0;
      end else begin
        m_word = w; m_dec = pc; m_fault = 0;
        m_next = (pc & 'o70000) | ((pc + 1) & 'o7777);
      end
    end
    if (rdy != 0) m_valid = v;
    m_pend = (acc != 0) ? 0 : ((m_pend != 0 || rq != 0) ? 1 : 0);
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 out_valid after reset", int'(out_valid), 0);
    chk("R10 out_fault after reset", int'(out_fault), 0);
    chk("R10 in_ready after reset", int'(in_ready), 1);
    rst = 1'b0;
    // R1: wrap of offset inside every field
    for (int f = 0; f < 8; f++) step(1, f * 'o10000 + 'o7777, 'o1234 + f, 0, 0, 0, 1);
    step(1, 'o23456, 'o7402, 0, 0, 0, 1);
    // R3 R4 R5: clean interrupt injection
    step(1, 'o00100, 'o1777, 1, 0, 0, 1);
    step(1, 'o00101, 'o2000, 0, 0, 0, 1);
    // R7: interrupt with nonzero data field, then instruction field
    step(1, 'o00200, 'o5000, 1, 2, 0, 1);
    step(1, 'o00300, 'o6000, 1, 0, 5, 1);
    step(1, 'o00301, 'o6001, 0, 3, 3, 1);
    // R9: request while idle stays pending until next accept, consumed once
    step(0, 0, 0, 1, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1);
    step(1, 'o01000, 'o3333, 0, 0, 0, 1);
    step(1, 'o01001, 'o3334, 0, 0, 0, 1);
    // R8: stall holds outputs, request during stall is latched
    step(1, 'o02000, 'o7000, 0, 0, 0, 1);
    step(1, 'o02001, 'o7001, 1, 0, 0, 0);
    step(1, 'o02001, 'o7001, 0, 0, 0, 0);
    step(1, 'o02001, 'o7001, 0, 0, 0, 1);
    step(1, 'o02002, 'o7002, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1);
    // mixed random traffic
    for (int i = 0; i < 3000; i++)
      step(($urandom % 4) != 0 ? 1 : 0, $urandom % 'o100000, $urandom % 'o10000,
           ($urandom % 9) == 0 ? 1 : 0, ($urandom % 3) == 0 ? int'($urandom % 8) : 0,
           ($urandom % 3) == 0 ? int'($urandom % 8) : 0, ($urandom % 3) != 0 ? 1 : 0);
    step(0, 0, 0, 0, 0, 0, 1);
    @(negedge clk);
    compare_out();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule